// File: doc/BRIEF.md
# Self-Reloading Descriptor DMA Channel

A single-channel DMA engine that walks a linked list of four-word descriptors in system memory. A descriptor holds a link word, a source address, a target address and a command word. Each descriptor is fetched whole, then executed as an alternating word copy: one read from the source, one write to the target. After that the channel follows the link to the next descriptor.

The block is built for a two-descriptor loop that lets a peripheral steer its own transfers. A header descriptor waits for the peripheral's request line. It then copies four words from the peripheral's fixed header window onto the payload descriptor in memory. Because those four words become the payload's link, source, target and command, the peripheral picks where its payload lands, how long it is, and whether the loop continues. The payload descriptor is fetched only after it has been rewritten. Its link points back to the header descriptor, which waits for the next request.

Top module: `hdr_reload_dma`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `mem_req_o`, `stopped_o`, `err_o` and `end_irq_o` are all low.
- R2: A descriptor fetch is four reads at the descriptor pointer plus 0, 4, 8 and 12, taken as link, source, target and command. No data access happens before all four reads finish.
- R3: When command bit 28 (wait-for-request) is set, the data phase does not begin until `req_i` is high. While it waits, no bus access occurs.
- R4: The byte length sits in command bits [LEN_W-1:0] as a multiple of 4. The data phase alternates one source read with one target write, moving length/4 words. Both addresses step up by 4 after each written word.
- R5: Words written by one descriptor onto the next descriptor's memory are the values that next descriptor runs with. The payload goes to the target address and length supplied by the peripheral.
- R6: When a descriptor ends and the stop bit (link bit 0) is clear, the channel fetches the next descriptor at the link address with bits [1:0] forced to zero.
- R7: If command bit 31 is set, a sticky `end_irq_o` rises when that descriptor ends. It stays high until a pulse on `clr_end_i`.
- R8: A link word with bit 0 set halts the channel once that descriptor ends. `busy_o` falls and a sticky `stopped_o` rises, which `clr_stop_i` clears.
- R9: A pulse on `stop_i` while running halts the channel at the end of the current descriptor, with the same status as R8. The next descriptor is not fetched.
- R10: A bus beat that completes with `mem_err_i` aborts the channel at once. `busy_o` falls, a sticky `err_o` rises (cleared by `clr_err_i`), and no further bus request is made.
- R11: A descriptor with zero length ends without any data access.
- R12: `start_i` while the channel is busy has no effect on the descriptor sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; loads `base_i` as first descriptor when idle |
| base_i | input | 32 | Address of the first descriptor |
| stop_i | input | 1 | Halt at the end of the current descriptor |
| req_i | input | 1 | Peripheral request line |
| clr_end_i | input | 1 | Clear end interrupt flag |
| clr_stop_i | input | 1 | Clear stopped flag |
| clr_err_i | input | 1 | Clear bus error flag |
| mem_req_o | output | 1 | Bus access request, held until `mem_ready_i` |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the word access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Beat completes this cycle |
| mem_err_i | input | 1 | Beat completes with a bus error |
| busy_o | output | 1 | Channel running |
| stopped_o | output | 1 | Sticky: halted by stop bit or stop pulse |
| err_o | output | 1 | Sticky: aborted by bus error |
| end_irq_o | output | 1 | Sticky end-of-descriptor interrupt |

## Verification
The header-then-payload loop runs over several passes. The peripheral supplies random target addresses and lengths of one to eight words, and the interrupt bit is set or clear at random. Every bus beat is logged and compared with the sequence expected from the requirements. A directed zero-length pass separates the "no data access" case from an off-by-one in the count. A stop bit on the final pass, a `stop_i` pulse during the header wait, and an error address on the source each end a run in a different way, and the status outputs tell these endings apart. A second start pulse during the request wait must leave the logged sequence unchanged, which shows it was ignored.

// File: rtl/hdr_dma_pkg.sv
package hdr_dma_pkg;
  localparam int WORD_W        = 32;
  localparam int CMD_IRQ_BIT   = 31;
  localparam int CMD_WAIT_BIT  = 28;
  localparam int LINK_STOP_BIT = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_READ, S_WRITE, S_DONE
  } st_e;

  // byte address of descriptor word idx
  function automatic logic [WORD_W-1:0] fetch_addr(logic [WORD_W-1:0] base, logic [1:0] idx);
    return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
  endfunction

  // next descriptor pointer from a link word
  function automatic logic [WORD_W-1:0] link_target(logic [WORD_W-1:0] link);
    return {link[WORD_W-1:2], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] word_next(logic [WORD_W-1:0] a);
    return a + WORD_W'(4);
  endfunction
endpackage

// File: rtl/hdr_dma_desc.sv
module hdr_dma_desc
  import hdr_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic [WORD_W-1:0] base_i,
  input  logic              follow,
  input  logic              ld_en,
  input  logic [1:0]        ld_idx,
  input  logic [WORD_W-1:0] word_i,
  input  logic              data_ld,
  input  logic              step,
  output logic [WORD_W-1:0] ptr_o,
  output logic [WORD_W-1:0] link_o,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] tgt_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              irq_en_o,
  output logic              wait_en_o,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [LEN_W-1:0] STEP_LEN = LEN_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o     <= '0;
      link_o    <= '0;
      src_o     <= '0;
      tgt_o     <= '0;
      rem_o     <= '0;
      irq_en_o  <= 1'b0;
      wait_en_o <= 1'b0;
      data_o    <= '0;
    end else begin
      if (load_base) ptr_o <= link_target(base_i);
      else if (follow) ptr_o <= link_target(link_o);
      if (ld_en) begin
        unique case (ld_idx)
          2'd0: link_o <= word_i;
          2'd1: src_o  <= word_i;
          2'd2: tgt_o  <= word_i;
          default: begin
            rem_o     <= {word_i[LEN_W-1:2], 2'b00};
            irq_en_o  <= word_i[CMD_IRQ_BIT];
            wait_en_o <= word_i[CMD_WAIT_BIT];
          end
        endcase
      end
      if (data_ld) data_o <= word_i;
      if (step) begin
        src_o <= word_next(src_o);
        tgt_o <= word_next(tgt_o);
        rem_o <= rem_o - STEP_LEN;
      end
    end
  end
endmodule

// File: rtl/hdr_dma_fsm.sv
module hdr_dma_fsm
  import hdr_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             req_i,
  input  logic             mem_ready_i,
  input  logic             mem_err_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic             link_stop_i,
  input  logic             wait_en_i,
  output st_e              st_o,
  output logic [1:0]       idx_o,
  output logic             bus_act_o,
  output logic             ld_en_o,
  output logic             data_ld_o,
  output logic             step_o,
  output logic             load_base_o,
  output logic             follow_o,
  output logic             done_evt_o,
  output logic             halt_evt_o,
  output logic             err_evt_o
);
  localparam logic [LEN_W-1:0] STEP_LEN = LEN_W'(4);

  st_e        st_q, st_d;
  logic [1:0] idx_q, idx_d;
  logic       stop_pend_q;
  logic       beat_ok, beat_err, last_word;

  assign bus_act_o   = (st_q == S_FETCH) || (st_q == S_READ) || (st_q == S_WRITE);
  assign beat_ok     = bus_act_o && mem_ready_i && !mem_err_i;
  assign beat_err    = bus_act_o && mem_ready_i && mem_err_i;
  assign last_word   = (rem_i == STEP_LEN);
  assign ld_en_o     = (st_q == S_FETCH) && beat_ok;
  assign data_ld_o   = (st_q == S_READ) && beat_ok;
  assign step_o      = (st_q == S_WRITE) && beat_ok;
  assign load_base_o = (st_q == S_IDLE) && start_i;
  assign done_evt_o  = (st_q == S_DONE);
  assign halt_evt_o  = done_evt_o && (link_stop_i || stop_pend_q);
  assign follow_o    = done_evt_o && !halt_evt_o;
  assign err_evt_o   = beat_err;
  assign st_o        = st_q;
  assign idx_o       = idx_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      S_IDLE:  if (start_i) begin st_d = S_FETCH; idx_d = 2'd0; end
      S_FETCH: begin
        if (beat_err) st_d = S_IDLE;
        else if (beat_ok) begin
          if (idx_q == 2'd3) st_d = S_CHECK;
          else idx_d = idx_q + 2'd1;
        end
      end
      S_CHECK: begin
        if (rem_i == '0) st_d = S_DONE;
        else if (wait_en_i) st_d = S_WAIT;
        else st_d = S_READ;
      end
      S_WAIT:  if (req_i) st_d = S_READ;
      S_READ: begin
        if (beat_err) st_d = S_IDLE;
        else if (beat_ok) st_d = S_WRITE;
      end
      S_WRITE: begin
        if (beat_err) st_d = S_IDLE;
        else if (beat_ok) st_d = last_word ? S_DONE : S_READ;
      end
      S_DONE: begin
        if (halt_evt_o) st_d = S_IDLE;
        else begin st_d = S_FETCH; idx_d = 2'd0; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      idx_q       <= 2'd0;
      stop_pend_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_d == S_IDLE) stop_pend_q <= 1'b0;
      else if (stop_i && st_q != S_IDLE) stop_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hdr_dma_status.sv
module hdr_dma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic end_set,
  input  logic end_clr,
  input  logic stop_set,
  input  logic stop_clr,
  input  logic err_set,
  input  logic err_clr,
  output logic end_o,
  output logic stop_o,
  output logic err_o
);
  // set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_o  <= 1'b0;
      stop_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (end_set) end_o <= 1'b1; else if (end_clr) end_o <= 1'b0;
      if (stop_set) stop_o <= 1'b1; else if (stop_clr) stop_o <= 1'b0;
      if (err_set) err_o <= 1'b1; else if (err_clr) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_reload_dma.sv
module hdr_reload_dma
  import hdr_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic              stop_i,
  input  logic              req_i,
  input  logic              clr_end_i,
  input  logic              clr_stop_i,
  input  logic              clr_err_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  input  logic              mem_err_i,
  output logic              busy_o,
  output logic              stopped_o,
  output logic              err_o,
  output logic              end_irq_o
);
  st_e               st;
  logic [1:0]        fetch_idx;
  logic              bus_act, ld_en, data_ld, step, load_base, follow;
  logic              done_evt, halt_evt, err_evt;
  logic [WORD_W-1:0] ptr, link, src, tgt, data_q;
  logic [LEN_W-1:0]  rem;
  logic              irq_en, wait_en;

  hdr_dma_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .req_i(req_i),
    .mem_ready_i(mem_ready_i), .mem_err_i(mem_err_i), .rem_i(rem),
    .link_stop_i(link[LINK_STOP_BIT]), .wait_en_i(wait_en),
    .st_o(st), .idx_o(fetch_idx), .bus_act_o(bus_act), .ld_en_o(ld_en),
    .data_ld_o(data_ld), .step_o(step), .load_base_o(load_base), .follow_o(follow),
    .done_evt_o(done_evt), .halt_evt_o(halt_evt), .err_evt_o(err_evt)
  );

  hdr_dma_desc #(.LEN_W(LEN_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .load_base(load_base), .base_i(base_i), .follow(follow),
    .ld_en(ld_en), .ld_idx(fetch_idx), .word_i(mem_rdata_i), .data_ld(data_ld),
    .step(step), .ptr_o(ptr), .link_o(link), .src_o(src), .tgt_o(tgt), .rem_o(rem),
    .irq_en_o(irq_en), .wait_en_o(wait_en), .data_o(data_q)
  );

  hdr_dma_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .end_set(done_evt && irq_en), .end_clr(clr_end_i),
    .stop_set(halt_evt), .stop_clr(clr_stop_i),
    .err_set(err_evt), .err_clr(clr_err_i),
    .end_o(end_irq_o), .stop_o(stopped_o), .err_o(err_o)
  );

  always_comb begin
    unique case (st)
      S_FETCH: mem_addr_o = fetch_addr(ptr, fetch_idx);
      S_READ:  mem_addr_o = src;
      S_WRITE: mem_addr_o = tgt;
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = bus_act;
  assign mem_we_o    = (st == S_WRITE);
  assign mem_wdata_o = (st == S_WRITE) ? data_q : '0;
  assign busy_o      = (st != S_IDLE);
endmodule

// File: rtl/hdr_dma_chk.sv
module hdr_dma_chk
  import hdr_dma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              clr_end_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic              mem_err_i,
  input logic              busy_o,
  input logic              stopped_o,
  input logic              err_o,
  input logic              end_irq_o,
  input st_e               st,
  input logic [1:0]        fetch_idx
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o); // R1
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_ready_i && !mem_err_i && fetch_idx != 2'd3)
      |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + 32'd4)); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !req_i) |=> !mem_req_o); // R3
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && mem_ready_i && !mem_err_i) |=> (mem_req_o && mem_we_o)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_irq_o && !clr_end_i) |=> end_irq_o); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_o) |-> !busy_o); // R8
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i && mem_err_i) |=> (!busy_o && err_o && !mem_req_o)); // R10
endmodule

bind hdr_reload_dma hdr_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_end_i(clr_end_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i), .mem_err_i(mem_err_i), .busy_o(busy_o),
  .stopped_o(stopped_o), .err_o(err_o), .end_irq_o(end_irq_o),
  .st(st), .fetch_idx(fetch_idx)
);

// File: tb/hdr_reload_dma_tb_top.sv
module hdr_reload_dma_tb_top;
  localparam int CLK_P   = 10;
  localparam logic [31:0] H_ADDR   = 32'h000;
  localparam logic [31:0] P_ADDR   = 32'h010;
  localparam logic [31:0] HDR_WIN  = 32'h300;
  localparam logic [31:0] DATA_WIN = 32'h380;
  localparam logic [31:0] ERR_ADDR = 32'h3F0;
  localparam logic [31:0] E_DESC   = 32'h040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, req_i = 0, clr_end_i = 0, clr_stop_i = 0, clr_err_i = 0;
  logic [31:0] base_i = '0;
  logic mem_req_o, mem_we_o, busy_o, stopped_o, err_o, end_irq_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic mem_ready_i = 0, mem_err_i = 0;

  logic [31:0] mem [0:255];
  logic [31:0] lg_addr [0:1023];
  logic        lg_we   [0:1023];
  logic [31:0] ex_addr [0:1023];
  logic        ex_we   [0:1023];
  int lg_n = 0, ex_n = 0, cmp_from = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  hdr_reload_dma dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .stop_i(stop_i),
    .req_i(req_i), .clr_end_i(clr_end_i), .clr_stop_i(clr_stop_i), .clr_err_i(clr_err_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .mem_err_i(mem_err_i), .busy_o(busy_o), .stopped_o(stopped_o), .err_o(err_o),
    .end_irq_o(end_irq_o)
  );

  // memory model with random wait states, logs every completed beat
  always @(negedge clk) begin
    mem_ready_i = 1'b0;
    mem_err_i   = 1'b0;
    if (mem_req_o && $urandom_range(0, 2) != 0) begin
      mem_ready_i = 1'b1;
      mem_err_i   = (mem_addr_o == ERR_ADDR);
      mem_rdata_i = mem[mem_addr_o[9:2]];
      if (mem_we_o && !mem_err_i) mem[mem_addr_o[9:2]] = mem_wdata_o;
      if (lg_n < 1024) begin
        lg_addr[lg_n] = mem_addr_o;
        lg_we[lg_n]   = mem_we_o;
        lg_n++;
      end
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(logic [31:0] a, logic we);
    ex_addr[ex_n] = a;
    ex_we[ex_n]   = we;
    ex_n++;
  endtask

  task automatic push_fetch(logic [31:0] d);
    for (int i = 0; i < 4; i++) push(d + 32'(4 * i), 1'b0);
  endtask

  task automatic push_copy(logic [31:0] s, logic [31:0] t, int n);
    for (int i = 0; i < n; i++) begin
      push(s + 32'(4 * i), 1'b0);
      push(t + 32'(4 * i), 1'b1);
    end
  endtask

  task automatic wait_log(int n);
    for (int c = 0; c < 3000 && lg_n < n; c++) @(negedge clk);
  endtask

  task automatic cmp_log(string rq);
    chk(rq, 32'(lg_n), 32'(ex_n), "beat count");
    for (int i = cmp_from; i < ex_n && i < lg_n; i++)
      chk(rq, {lg_we[i], lg_addr[i][30:0]}, {ex_we[i], ex_addr[i][30:0]}, "beat we/addr");
    cmp_from = ex_n;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(bit irq, bit wt, int bytes);
    return {irq, 2'b00, wt, 28'(bytes)};
  endfunction

  // one header + payload pass of the self-reloading loop
  task automatic run_pass(logic [31:0] dest, int n, bit irq, bit last, string rq);
    logic [31:0] dat [0:7];
    mem[HDR_WIN[9:2] + 0] = H_ADDR | {31'd0, last};
    mem[HDR_WIN[9:2] + 1] = DATA_WIN;
    mem[HDR_WIN[9:2] + 2] = dest;
    mem[HDR_WIN[9:2] + 3] = cmd_word(irq, 1'b0, 4 * n);
    for (int i = 0; i < 8; i++) begin
      dat[i] = $urandom;
      mem[DATA_WIN[9:2] + 8'(i)] = dat[i];
    end
    push_copy(HDR_WIN, P_ADDR, 4);
    push_fetch(P_ADDR);
    push_copy(DATA_WIN, dest, n);
    if (!last) push_fetch(H_ADDR);
    @(negedge clk); req_i = 1'b1;
    wait_log(cmp_from + 1);
    req_i = 1'b0;
    wait_log(ex_n);
    repeat (6) @(negedge clk);
    cmp_log(rq);
    for (int i = 0; i < n; i++) chk("R5", mem[dest[9:2] + 8'(i)], dat[i], "payload word at peripheral target");
    chk("R7", 32'(end_irq_o), 32'(irq), "end interrupt");
    if (irq) begin
      pulse(clr_end_i);
      chk("R7", 32'(end_irq_o), 32'd0, "end interrupt after clear");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[H_ADDR[9:2] + 0] = P_ADDR;
    mem[H_ADDR[9:2] + 1] = HDR_WIN;
    mem[H_ADDR[9:2] + 2] = P_ADDR;
    mem[H_ADDR[9:2] + 3] = cmd_word(1'b0, 1'b1, 16);
    repeat (3) @(negedge clk);
    chk("R1", {27'd0, busy_o, mem_req_o, stopped_o, err_o, end_irq_o}, 32'd0, "status in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {27'd0, busy_o, mem_req_o, stopped_o, err_o, end_irq_o}, 32'd0, "status after reset");

    // start; header descriptor must wait for the request
    push_fetch(H_ADDR);
    base_i = H_ADDR;
    pulse(start_i);
    wait_log(4);
    repeat (20) @(negedge clk);
    cmp_log("R2");
    chk("R3", {30'd0, busy_o, mem_req_o}, 32'd2, "busy and quiet while awaiting request");
    base_i = E_DESC;
    pulse(start_i);  // R12: must be ignored
    repeat (10) @(negedge clk);
    chk("R12", 32'(lg_n), 32'd4, "no new fetch after start while busy");

    run_pass(32'h100, 3, 1'b1, 1'b0, "R4");
    run_pass(32'h180, 0, 1'b1, 1'b0, "R11");
    for (int p = 0; p < 4; p++)
      run_pass(32'h100 + 32'(4 * $urandom_range(0, 96)), $urandom_range(1, 8), 1'($urandom_range(0, 1)), 1'b0, "R6");
    run_pass(32'h200, 5, 1'b0, 1'b1, "R8");
    chk("R8", {30'd0, busy_o, stopped_o}, 32'd1, "halted by link stop bit");
    pulse(clr_stop_i);
    chk("R8", 32'(stopped_o), 32'd0, "stopped after clear");

    // R9: stop pulse while the header waits
    push_fetch(H_ADDR);
    base_i = H_ADDR;
    pulse(start_i);
    wait_log(cmp_from + 4);
    pulse(stop_i);
    mem[HDR_WIN[9:2] + 0] = H_ADDR;
    mem[HDR_WIN[9:2] + 3] = cmd_word(1'b0, 1'b0, 8);
    push_copy(HDR_WIN, P_ADDR, 4);
    req_i = 1'b1;
    wait_log(cmp_from + 5);
    req_i = 1'b0;
    wait_log(ex_n);
    repeat (10) @(negedge clk);
    cmp_log("R9");
    chk("R9", {30'd0, busy_o, stopped_o}, 32'd1, "halted by stop pulse");
    pulse(clr_stop_i);

    // R10: source hits an erroring address
    mem[E_DESC[9:2] + 0] = H_ADDR;
    mem[E_DESC[9:2] + 1] = ERR_ADDR;
    mem[E_DESC[9:2] + 2] = 32'h100;
    mem[E_DESC[9:2] + 3] = cmd_word(1'b1, 1'b0, 8);
    push_fetch(E_DESC);
    push(ERR_ADDR, 1'b0);
    base_i = E_DESC;
    pulse(start_i);
    wait_log(ex_n);
    repeat (10) @(negedge clk);
    cmp_log("R10");
    chk("R10", {29'd0, busy_o, err_o, end_irq_o}, 32'd2, "aborted with error flag");
    pulse(clr_err_i);
    chk("R10", 32'(err_o), 32'd0, "error flag after clear");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule